// File: doc/BRIEF.md
# DMA Channel Completion Status Unit

This block holds the control and completion state of one DMA channel. Software programs a transfer count and then starts the channel through a small synchronous write port. The datapath reports each finished bus cycle with a one-cycle strobe, and it holds a busy level while a bus cycle is in flight. The unit counts transfers down to the end and stops the channel there. It raises a transfer-end flag and drives a level interrupt while both the flag and its enable are set.

Software can also stop a running channel. The stop takes effect at once when no bus cycle is outstanding. Otherwise the channel drains the cycle in flight, counts it, and only then reports the end. Starting the channel again clears the end flag and drops any latched transfer request, so a resumed transfer begins clean.

Register map. Address 0 is the count register; `wr_data_i` is the full count. Address 1 is the control register, with these bits:
- bit 0: enable
- bit 1: active
- bit 2: interrupt enable
- bit 3: flag clear, write 1

Top module: `dma_chan_status`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `en_o`, `act_o`, `flag_o`, `irq_o` and `xfer_req_o` are all 0, and the interrupt enable is 0.
- R2: A write to address 0 while the channel is idle loads `count_o` on the next edge. Each `cyc_done_i` pulse while `en_o` is 1 lowers `count_o` by one. A `cyc_done_i` pulse while idle leaves `count_o` unchanged.
- R3: A `cyc_done_i` pulse while running with `count_o` equal to 1 does four things on the same edge: it drives `count_o` to 0, sets `flag_o`, and clears `en_o` and `act_o`.
- R4: A programmed count of 0 gives 65536 transfers. After 65535 strobes the channel still runs with `count_o` equal to 1 and `flag_o` at 0. The next strobe ends the transfer.
- R5: `irq_o` is 1 exactly while `flag_o` and the interrupt enable (control bit 2, updated on every control write) are both 1. Clearing the enable drops `irq_o` and leaves `flag_o` set.
- R6: A control write while running with bit 0 or bit 1 at 0 is a stop. With `cyc_busy_i` low and no `cyc_done_i`, the next edge gives `en_o`=0, `act_o`=0 and `flag_o`=1, and `count_o` is unchanged.
- R7: A stop while `cyc_busy_i` is 1 and `cyc_done_i` is 0 gives `act_o`=0 and `en_o`=1 with `flag_o` still 0. This state holds until `cyc_done_i`. That strobe lowers the count by one, sets `flag_o` and clears `en_o`.
- R8: A control write with bit 0 set while idle starts the channel (`en_o`=`act_o`=1). The start clears `flag_o` and any latched transfer request.
- R9: When a stop write and the last counted `cyc_done_i` fall in the same cycle, the channel ends idle with `count_o`=0 and `flag_o`=1.
- R10: A write to address 0 while `en_o` is 1 is ignored.
- R11: Control bit 3 written as 1 clears `flag_o`. If the flag is set by an end event in the same cycle, the set wins.
- R12: `xfer_req_i` seen while running latches a request, shown on `xfer_req_o` while running. A `cyc_done_i` pulse without a new request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address (0 count, 1 control) |
| wr_data_i | input | CNT_W | Write data |
| cyc_busy_i | input | 1 | Bus cycle in flight |
| cyc_done_i | input | 1 | Bus cycle finished, one-cycle strobe |
| xfer_req_i | input | 1 | Transfer request from the requester |
| count_o | output | CNT_W | Remaining transfer count |
| en_o | output | 1 | Channel enabled |
| act_o | output | 1 | Channel actively transferring |
| flag_o | output | 1 | Transfer-end flag |
| irq_o | output | 1 | Transfer-end interrupt, level |
| xfer_req_o | output | 1 | Latched transfer request toward arbitration |

## Verification
The hardest situations to reach are the ones where two events land on the same edge. One is a stop write on the very cycle the final transfer completes. Another is a flag-clear write on the cycle an end event sets the flag. A third is the drain state, where the stop arrives with a bus cycle still outstanding. The vector table reaches each of these by first running the count down to 1 with single strobes. It then applies the write together with `cyc_done_i` or `cyc_busy_i` in one row. A directed run holds the strobe high for 65535 cycles to reach the wrap case of a zero count.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;

  localparam int unsigned REG_COUNT = 0;
  localparam int unsigned REG_CTRL  = 1;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_ACT = 1;
  localparam int unsigned CTL_IE  = 2;
  localparam int unsigned CTL_CLR = 3;
  localparam int unsigned CTL_W   = 4;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 1
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CTL_W-1:0]  ctl_bits_i,
  input  ch_state_e         state_i,
  output logic              cnt_wr_o,
  output logic              ctl_wr_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              ie_val_o,
  output logic              clr_o
);
  logic cnt_sel, ctl_sel;

  assign cnt_sel = wr_en_i && (wr_addr_i == ADDR_W'(REG_COUNT));
  assign ctl_sel = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));

  // count is writable only while idle
  assign cnt_wr_o = cnt_sel && (state_i == CH_IDLE);
  assign ctl_wr_o = ctl_sel;
  assign start_o  = ctl_sel && (state_i == CH_IDLE) && ctl_bits_i[CTL_EN];
  assign stop_o   = ctl_sel && (state_i == CH_RUN)
                  && !(ctl_bits_i[CTL_EN] && ctl_bits_i[CTL_ACT]);
  assign ie_val_o = ctl_bits_i[CTL_IE];
  assign clr_o    = ctl_sel && ctl_bits_i[CTL_CLR];
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_ONE;  // 0 wraps: full 2**CNT_W run
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_ONE);

  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_stat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      done_i,
  input  logic      busy_i,
  input  logic      last_i,
  input  logic      req_i,
  output ch_state_e state_o,
  output logic      dec_o,
  output logic      end_o,
  output logic      xfer_req_o
);
  ch_state_e state_q, state_d;
  logic      req_q;

  always_comb begin
    state_d = state_q;
    end_o   = 1'b0;
    unique case (state_q)
      CH_IDLE: if (start_i) state_d = CH_RUN;
      CH_RUN: begin
        if (done_i && last_i) begin
          state_d = CH_IDLE;
          end_o   = 1'b1;
        end else if (stop_i) begin
          if (busy_i && !done_i) begin
            state_d = CH_DRAIN;
          end else begin
            state_d = CH_IDLE;
            end_o   = 1'b1;
          end
        end
      end
      CH_DRAIN: if (done_i) begin
        state_d = CH_IDLE;
        end_o   = 1'b1;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  req_q <= 1'b0;
    else if (start_i)             req_q <= 1'b0;
    else if (state_q != CH_RUN)   req_q <= 1'b0;
    else if (state_d != CH_RUN)   req_q <= 1'b0;
    else if (req_i)               req_q <= 1'b1;
    else if (done_i)              req_q <= 1'b0;
  end

  assign state_o    = state_q;
  assign dec_o      = done_i && (state_q != CH_IDLE);
  assign xfer_req_o = req_q && (state_q == CH_RUN);

  // R3
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_RUN && done_i && last_i) |=> (state_q == CH_IDLE));

  // R7
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_DRAIN && !done_i) |=> (state_q == CH_DRAIN));
endmodule

// File: rtl/dma_end_flag.sv
module dma_end_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic start_i,
  input  logic ie_wr_i,
  input  logic ie_val_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (set_i)            flag_q <= 1'b1;   // set beats clear
    else if (clr_i || start_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (ie_wr_i) ie_q <= ie_val_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_q;

  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i && !start_i && !ie_wr_i) |=> irq_o);

  // R8
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              cyc_busy_i,
  input  logic              cyc_done_i,
  input  logic              xfer_req_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              en_o,
  output logic              act_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              xfer_req_o
);
  ch_state_e state;
  logic cnt_wr, ctl_wr, start, stop, ie_val, clr;
  logic dec, last, end_evt;

  dma_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .ctl_bits_i (wr_data_i[CTL_W-1:0]),
    .state_i    (state),
    .cnt_wr_o   (cnt_wr),
    .ctl_wr_o   (ctl_wr),
    .start_o    (start),
    .stop_o     (stop),
    .ie_val_o   (ie_val),
    .clr_o      (clr)
  );

  dma_xfer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i),
    .dec_i      (dec),
    .cnt_o      (count_o),
    .last_o     (last)
  );

  dma_chan_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .done_i     (cyc_done_i),
    .busy_i     (cyc_busy_i),
    .last_i     (last),
    .req_i      (xfer_req_i),
    .state_o    (state),
    .dec_o      (dec),
    .end_o      (end_evt),
    .xfer_req_o (xfer_req_o)
  );

  dma_end_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (end_evt),
    .clr_i    (clr),
    .start_i  (start),
    .ie_wr_i  (ctl_wr),
    .ie_val_i (ie_val),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  assign en_o  = (state != CH_IDLE);
  assign act_o = (state == CH_RUN);

  // R2
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && cyc_done_i && !(wr_en_i && wr_addr_i == ADDR_W'(REG_COUNT)))
    |=> $stable(count_o));

  // R10
  cnt_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !cyc_done_i && wr_en_i && wr_addr_i == ADDR_W'(REG_COUNT))
    |=> $stable(count_o));

  // R9
  stop_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && stop && cyc_done_i && count_o == CNT_W'(1))
    |=> (!en_o && flag_o && count_o == '0));
endmodule

// File: tb/dma_chan_status_bench.sv
`timescale 1ns/1ps
module dma_chan_status_bench;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 1;
  localparam int unsigned VW     = 42;
  localparam int unsigned NV     = 30;

  // {op[1:0] (1 count wr, 2 ctrl wr), data[15:0], done, busy, req, exp_cnt[15:0], exp {en,act,flag,irq,xreq}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 16'h0003, 3'b000, 16'd3, 5'b00000},
    {2'd2, 16'h0007, 3'b000, 16'd3, 5'b11000},
    {2'd0, 16'h0000, 3'b001, 16'd3, 5'b11001},
    {2'd0, 16'h0000, 3'b110, 16'd2, 5'b11000},
    {2'd0, 16'h0000, 3'b100, 16'd1, 5'b11000},
    {2'd0, 16'h0000, 3'b100, 16'd0, 5'b00110},
    {2'd2, 16'h000C, 3'b000, 16'd0, 5'b00000},
    {2'd1, 16'h0005, 3'b000, 16'd5, 5'b00000},
    {2'd2, 16'h0003, 3'b000, 16'd5, 5'b11000},
    {2'd1, 16'h0009, 3'b000, 16'd5, 5'b11000},
    {2'd2, 16'h0001, 3'b010, 16'd5, 5'b10000},
    {2'd0, 16'h0000, 3'b010, 16'd5, 5'b10000},
    {2'd0, 16'h0000, 3'b110, 16'd4, 5'b00100},
    {2'd2, 16'h0007, 3'b000, 16'd4, 5'b11000},
    {2'd2, 16'h0005, 3'b000, 16'd4, 5'b00110},
    {2'd2, 16'h0003, 3'b000, 16'd4, 5'b11000},
    {2'd0, 16'h0000, 3'b001, 16'd4, 5'b11001},
    {2'd0, 16'h0000, 3'b100, 16'd3, 5'b11000},
    {2'd0, 16'h0000, 3'b100, 16'd2, 5'b11000},
    {2'd0, 16'h0000, 3'b100, 16'd1, 5'b11000},
    {2'd2, 16'h0004, 3'b110, 16'd0, 5'b00110},
    {2'd2, 16'h000C, 3'b000, 16'd0, 5'b00000},
    {2'd1, 16'h0001, 3'b000, 16'd1, 5'b00000},
    {2'd2, 16'h0007, 3'b000, 16'd1, 5'b11000},
    {2'd0, 16'h0000, 3'b100, 16'd0, 5'b00110},
    {2'd2, 16'h0000, 3'b000, 16'd0, 5'b00100},
    {2'd0, 16'h0000, 3'b100, 16'd0, 5'b00100},
    {2'd1, 16'h0001, 3'b000, 16'd1, 5'b00100},
    {2'd2, 16'h0007, 3'b000, 16'd1, 5'b11000},
    {2'd2, 16'h000F, 3'b100, 16'd0, 5'b00110}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [CNT_W-1:0]  wr_data_i = '0;
  logic              cyc_busy_i = 1'b0;
  logic              cyc_done_i = 1'b0;
  logic              xfer_req_i = 1'b0;
  logic [CNT_W-1:0]  count_o;
  logic              en_o, act_o, flag_o, irq_o, xfer_req_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_status #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dma_chan_status (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cyc_busy_i(cyc_busy_i), .cyc_done_i(cyc_done_i),
    .xfer_req_i(xfer_req_i), .count_o(count_o), .en_o(en_o), .act_o(act_o),
    .flag_o(flag_o), .irq_o(irq_o), .xfer_req_o(xfer_req_o)
  );

  task automatic chk(input string tag, input logic [CNT_W-1:0] exp_cnt,
                     input logic [4:0] exp_st);
    logic [4:0] st;
    st = {en_o, act_o, flag_o, irq_o, xfer_req_o};
    n_run++;
    if (count_o !== exp_cnt || st !== exp_st) begin
      n_fail++;
      $display("FAIL %s: count=%0d status=%b expected count=%0d status=%b",
               tag, count_o, st, exp_cnt, exp_st);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      1, 8, 13, 15, 23, 28: return "R8 start";
      2, 3, 16, 17:         return "R12 request";
      5:                    return "R3 terminal";
      6, 21, 29:            return "R11 flag clear";
      9:                    return "R10 count locked";
      10, 11, 12:           return "R7 drain stop";
      14:                   return "R6 immediate stop";
      20:                   return "R9 stop on last";
      24, 25:               return "R5 irq level";
      default:              return "R2 count";
    endcase
  endfunction

  task automatic idle_inputs();
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    cyc_busy_i = 1'b0; cyc_done_i = 1'b0; xfer_req_i = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R4 watchdog: run incomplete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] v;
    #1;
    chk("R1 reset", '0, 5'b00000);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < int'(NV); i++) begin
      v = VEC[i];
      @(negedge clk);
      wr_en_i    = (v[41:40] != 2'd0);
      wr_addr_i  = ADDR_W'(v[41:40] == 2'd2);
      wr_data_i  = v[39:24];
      cyc_done_i = v[23];
      cyc_busy_i = v[22];
      xfer_req_i = v[21];
      @(posedge clk); #1;
      chk(row_tag(i), v[20:5], v[4:0]);
    end
    @(negedge clk); idle_inputs();

    // R1: reset in the middle of activity (flag and irq set)
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", '0, 5'b00000);
    @(negedge clk); rst_ni = 1'b1;

    // R5: after reset the interrupt enable is 0, so an end gives no irq
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 16'd1;
    @(negedge clk); wr_addr_i = 1'b1; wr_data_i = 16'h0003;
    @(negedge clk); wr_en_i = 1'b0; cyc_done_i = 1'b1;
    @(posedge clk); #1;
    chk("R5 ie reset value", '0, 5'b00100);
    @(negedge clk); idle_inputs();

    // R4: zero count means 65536 transfers
    wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 16'd0;
    @(negedge clk); wr_addr_i = 1'b1; wr_data_i = 16'h0007;
    @(posedge clk); #1;
    chk("R4 start zero count", 16'd0, 5'b11000);
    @(negedge clk); wr_en_i = 1'b0; cyc_done_i = 1'b1;
    repeat (65535) @(posedge clk);
    #1;
    chk("R4 before last", 16'd1, 5'b11000);
    @(posedge clk); #1;
    chk("R4 after last", 16'd0, 5'b00110);
    @(negedge clk); idle_inputs();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule